// File: doc/BRIEF.md
# Stepper Excitation Position Sequencer

This block is the digital heart of a two-phase stepper motor driver. It keeps an electrical excitation position, 64 positions per electrical cycle, that moves one step on every rising and every falling edge of a step-clock input. The direction input selects whether it moves forward or backward. From that position it forms a signed current setpoint for each phase: a 7-bit magnitude code and a polarity bit. The analog side of the driver (D/A, chopping comparator, bridges) consumes these codes.

Three excitation styles are offered: full-step, half-step and microstep. A fourth mode-select code requests power-save. In power-save the position is frozen and step edges are ignored. A chip-level reset request, raised by the surrounding logic on its reset decode or on undervoltage, disables the bridges and reloads the starting position. An output-enable input turns the bridges off without stopping the position counter. When the mode changes from microstep to a coarser style, the block holds the fine position. The next step edge then moves it to the first legal position of the new style ahead in the commanded direction.

Top module: `stepper_seq`

## Requirements
- R1: After the system reset is released, or while `chip_rst` is high, the position loads its start value. In microstep (`mode_sel`=2) and half-step (`mode_sel`=1) this is A=127 positive, B=0. In full-step (`mode_sel`=0) it is A=127 and B=127, both positive.
- R2: Every change of `step_in`, rising or falling, moves the position by one step. The new codes appear on the outputs within 3 `clk` cycles of the change. While `step_in` holds its level, the outputs do not change.
- R3: With `dir_cw`=1 the position counts up, and phase B lags phase A by 90 degrees. With `dir_cw`=0 it counts down, and B leads A. In microstep, one CW step from the start gives A=126 and B=12, both positive. One CCW step from the start gives A=126 positive and B=12 negative.
- R4: The magnitude codes are the cosine (phase A) and sine (phase B) of position×5.625 degrees, scaled so that 127 is 100% and rounded to the nearest integer. Over a quarter wave this gives 127, 126, 125, 122, 117, 112, 106, 98, 90, 81, 71, 60, 49, 37, 25, 12, 0.
- R5: A polarity bit of 1 means current flows from output B to output A. A zero magnitude always reports polarity 0.
- R6: In full-step mode each edge moves the position by 90 degrees. The full-step positions are 8, 24, 40 and 56 (45 degrees plus a multiple of 90). At those positions both magnitudes are 127.
- R7: In half-step mode each edge moves the position by 45 degrees, through the multiples of 8. At the diagonal positions both phases read 90 (70.7%).
- R8: After a switch from microstep to full-step or half-step, an off-grid position is held unchanged until the next edge. That edge moves the position to the first legal position of the new mode strictly beyond the old one in the commanded direction.
- R9: While `oe_in` is low, `drive_en` is low, but step edges still advance the position.
- R10: With `mode_sel`=3 (power-save), `drive_en` is low and step edges are ignored. After power-save ends, stepping resumes from the held position.
- R11: While `chip_rst` is high, `drive_en` is low and step edges are ignored. Edges that toggle during the request leave no pending step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| chip_rst | input | 1 | Synchronous chip-level reset request (reset decode or undervoltage) |
| step_in | input | 1 | Step clock, both edges count, asynchronous |
| dir_cw | input | 1 | Direction, 1 = forward (CW), asynchronous |
| oe_in | input | 1 | Bridge output enable |
| mode_sel | input | 2 | 0 full-step, 1 half-step, 2 microstep, 3 power-save |
| drive_en | output | 1 | High when the bridges may be driven, low for Hi-Z |
| a_mag | output | 7 | Phase A current magnitude code |
| a_neg | output | 1 | Phase A polarity |
| b_mag | output | 7 | Phase B current magnitude code |
| b_neg | output | 1 | Phase B polarity |

## Verification
Two pairs of events can fall in the same cycle: a step edge together with a chip-reset request, and a step edge together with a change of mode. The bench toggles the step input repeatedly while the reset request is held. It then checks that the start position wins and that no deferred step shows up after release. Next it leaves the position off-grid in microstep, switches to full-step or half-step, and steps in each direction. Each time it compares the landing position with the target expected for that direction. The same check runs from inside a quadrant and from past a quadrant's midpoint.

// File: rtl/stepper_seq.sv
module stepper_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_rst,
  input  logic       step_in,
  input  logic       dir_cw,
  input  logic       oe_in,
  input  logic [1:0] mode_sel,
  output logic       drive_en,
  output logic [6:0] a_mag,
  output logic       a_neg,
  output logic [6:0] b_mag,
  output logic       b_neg
);

  typedef enum logic [1:0] {M_FULL = 2'd0, M_HALF = 2'd1, M_MICRO = 2'd2, M_PSAVE = 2'd3} mode_t;

  localparam logic [6:0] FULL_MAG = 7'd127;

  mode_t mode;
  assign mode = mode_t'(mode_sel);

  logic [SYNC_STAGES:0]   stp_sh;
  logic [SYNC_STAGES-1:0] dir_sh;
  logic                   init_done;
  logic [5:0]             pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stp_sh <= '0;
      dir_sh <= '0;
    end else begin
      stp_sh <= {stp_sh[SYNC_STAGES-1:0], step_in};
      dir_sh <= {dir_sh[SYNC_STAGES-2:0], dir_cw};
    end
  end

  logic step_edge, dir_fwd, hold_rst;
  assign step_edge = stp_sh[SYNC_STAGES] ^ stp_sh[SYNC_STAGES-1];
  assign dir_fwd   = dir_sh[SYNC_STAGES-1];
  assign hold_rst  = chip_rst | ~init_done;

  logic [5:0] grid_m, stride, offs, rel, fwd_pos, bwd_pos, start_pos;

  always_comb begin
    case (mode)
      M_FULL:  begin grid_m = 6'b110000; stride = 6'd16; offs = 6'd8; end
      M_HALF:  begin grid_m = 6'b111000; stride = 6'd8;  offs = 6'd0; end
      default: begin grid_m = 6'b111111; stride = 6'd1;  offs = 6'd0; end
    endcase
  end

  assign rel       = pos - offs;
  assign fwd_pos   = (rel & grid_m) + stride + offs;
  assign bwd_pos   = ((rel - 6'd1) & grid_m) + offs;
  assign start_pos = (mode == M_FULL) ? 6'd8 : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      pos       <= '0;
    end else begin
      init_done <= 1'b1;
      if (hold_rst)
        pos <= start_pos;
      else if (step_edge && mode != M_PSAVE)
        pos <= dir_fwd ? fwd_pos : bwd_pos;
    end
  end

  function automatic logic [6:0] qwave(input logic [4:0] i);
    case (i)
      5'd0:  qwave = 7'd127;
      5'd1:  qwave = 7'd126;
      5'd2:  qwave = 7'd125;
      5'd3:  qwave = 7'd122;
      5'd4:  qwave = 7'd117;
      5'd5:  qwave = 7'd112;
      5'd6:  qwave = 7'd106;
      5'd7:  qwave = 7'd98;
      5'd8:  qwave = 7'd90;
      5'd9:  qwave = 7'd81;
      5'd10: qwave = 7'd71;
      5'd11: qwave = 7'd60;
      5'd12: qwave = 7'd49;
      5'd13: qwave = 7'd37;
      5'd14: qwave = 7'd25;
      5'd15: qwave = 7'd12;
      default: qwave = 7'd0;
    endcase
  endfunction

  logic [1:0] quad;
  logic [3:0] k;
  logic [6:0] cos_m, sin_m, a_raw, b_raw;
  logic       full_top;

  assign quad     = pos[5:4];
  assign k        = pos[3:0];
  assign cos_m    = qwave({1'b0, k});
  assign sin_m    = qwave(5'd16 - {1'b0, k});
  assign a_raw    = quad[0] ? sin_m : cos_m;
  assign b_raw    = quad[0] ? cos_m : sin_m;
  assign full_top = (mode == M_FULL) && (k == 4'd8);

  assign a_mag    = full_top ? FULL_MAG : a_raw;
  assign b_mag    = full_top ? FULL_MAG : b_raw;
  assign a_neg    = (quad[1] ^ quad[0]) && (a_mag != 7'd0);
  assign b_neg    = quad[1] && (b_mag != 7'd0);
  assign drive_en = oe_in && !hold_rst && (mode != M_PSAVE);

  p_hold_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !chip_rst && !step_edge) |=> $stable(pos));

  p_micro_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !chip_rst && step_edge && mode == M_MICRO)
      |=> (pos == $past(pos) + 6'd1 || pos == $past(pos) - 6'd1));

  p_full_grid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !chip_rst && step_edge && mode == M_FULL) |=> (pos[3:0] == 4'd8));

  p_half_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !chip_rst && step_edge && mode == M_HALF) |=> (pos[2:0] == 3'd0));

  p_psave_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !chip_rst && mode == M_PSAVE) |=> $stable(pos));

  p_rst_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && mode == M_FULL) |=> (pos == 6'd8));

  p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mag == 7'd0) |-> !a_neg);

endmodule

// File: tb/test_stepper_seq.sv
module test_stepper_seq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       chip_rst = 0;
  logic       step_in = 0;
  logic       dir_cw = 1;
  logic       oe_in = 1;
  logic [1:0] mode_sel = 2'd2;
  logic       drive_en, a_neg, b_neg;
  logic [6:0] a_mag, b_mag;

  int checks = 0;
  int errors = 0;
  int mp = 0;

  always #5 clk = ~clk;

  stepper_seq i_stepper_seq (
    .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .step_in(step_in),
    .dir_cw(dir_cw), .oe_in(oe_in), .mode_sel(mode_sel), .drive_en(drive_en),
    .a_mag(a_mag), .a_neg(a_neg), .b_mag(b_mag), .b_neg(b_neg)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_pos(input int p, input string tag);
    real ang, ca, sb;
    int am, bm, q;
    bit an, bn;
    q = ((p % 64) + 64) % 64;
    ang = 2.0 * 3.14159265358979 * q / 64.0;
    ca = $cos(ang) * 127.0;
    sb = $sin(ang) * 127.0;
    am = $rtoi((ca < 0 ? -ca : ca) + 0.5);
    bm = $rtoi((sb < 0 ? -sb : sb) + 0.5);
    if (mode_sel == 2'd0 && (q % 16) == 8) begin am = 127; bm = 127; end
    an = (ca < 0) && (am != 0);
    bn = (sb < 0) && (bm != 0);
    check_val({tag, " a_mag"}, a_mag, am);
    check_val({tag, " a_neg"}, a_neg, an);
    check_val({tag, " b_mag"}, b_mag, bm);
    check_val({tag, " b_neg"}, b_neg, bn);
  endtask

  task automatic step();
    @(negedge clk) step_in = ~step_in;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chip_reset(input logic [1:0] m);
    @(negedge clk) begin mode_sel = m; chip_rst = 1; end
    settle(3);
    chip_rst = 0;
    settle(3);
    mp = (m == 2'd0) ? 8 : 0;
  endtask

  task automatic t_reset();
    rst_n = 0; mode_sel = 2'd2; dir_cw = 1; oe_in = 1;
    settle(3);
    rst_n = 1;
    settle(4);
    mp = 0;
    expect_pos(0, "R1 micro start");
    check_val("R1 drive_en after reset", drive_en, 1);
    chip_reset(2'd1);
    expect_pos(0, "R1 half start");
    chip_reset(2'd0);
    expect_pos(8, "R1 full start");
  endtask

  task automatic t_micro();
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    step(); mp = 1;
    check_val("R3 cw first A", a_mag, 126);
    check_val("R3 cw first B", b_mag, 12);
    check_val("R3 cw first B sign", b_neg, 0);
    for (int i = 0; i < 39; i++) begin
      step(); mp++;
      expect_pos(mp, "R4 micro cw");
    end
    settle(30);
    expect_pos(mp, "R2 level held");
    dir_cw = 0; settle(4);
    for (int i = 0; i < 45; i++) begin
      step(); mp--;
      expect_pos(mp, "R3 micro ccw");
    end
    chip_reset(2'd2);
    step(); mp = -1;
    check_val("R3 ccw first A", a_mag, 126);
    check_val("R3 ccw first B", b_mag, 12);
    check_val("R3 ccw first B sign", b_neg, 1);
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 32; i++) step();
    mp = 32;
    check_val("R5 half cycle A sign", a_neg, 1);
    check_val("R5 half cycle B zero sign", b_neg, 0);
    check_val("R5 half cycle B", b_mag, 0);
  endtask

  task automatic t_full();
    chip_reset(2'd0);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 5; i++) begin
      step(); mp += 16;
      expect_pos(mp, "R6 full cw");
      check_val("R6 full both A", a_mag, 127);
    end
    dir_cw = 0; settle(4);
    for (int i = 0; i < 2; i++) begin
      step(); mp -= 16;
      expect_pos(mp, "R6 full ccw");
    end
  endtask

  task automatic t_half();
    chip_reset(2'd1);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 9; i++) begin
      step(); mp += 8;
      expect_pos(mp, "R7 half cw");
    end
  endtask

  task automatic t_realign();
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 3; i++) step();
    mode_sel = 2'd0; settle(4);
    expect_pos(3, "R8 held after switch");
    step(); expect_pos(8, "R8 full cw from 3");
    mode_sel = 2'd2; settle(2);
    for (int i = 0; i < 3; i++) step();
    dir_cw = 0; mode_sel = 2'd0; settle(4);
    step(); expect_pos(8, "R8 full ccw from 11");
    mode_sel = 2'd2; dir_cw = 1; settle(4);
    for (int i = 0; i < 5; i++) step();
    dir_cw = 0; mode_sel = 2'd1; settle(4);
    step(); expect_pos(8, "R8 half ccw from 13");
    mode_sel = 2'd2; dir_cw = 1; settle(4);
    for (int i = 0; i < 9; i++) step();
    mode_sel = 2'd1; settle(2);
    step(); expect_pos(24, "R8 half cw from 17");
    mode_sel = 2'd2; settle(2);
    for (int i = 0; i < 3; i++) step();
    mode_sel = 2'd0; settle(2);
    step(); expect_pos(40, "R8 full cw from 27");
  endtask

  task automatic t_oe();
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    oe_in = 0; settle(2);
    check_val("R9 drive_en low", drive_en, 0);
    for (int i = 0; i < 4; i++) step();
    oe_in = 1; settle(2);
    check_val("R9 drive_en back", drive_en, 1);
    expect_pos(4, "R9 advanced while disabled");
  endtask

  task automatic t_psave();
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 5; i++) step();
    mode_sel = 2'd3; settle(3);
    check_val("R10 drive_en low", drive_en, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      expect_pos(5, "R10 edge ignored");
    end
    mode_sel = 2'd2; settle(4);
    check_val("R10 drive_en resumes", drive_en, 1);
    step(); expect_pos(6, "R10 resume");
  endtask

  task automatic t_chiprst();
    chip_reset(2'd2);
    dir_cw = 1; settle(4);
    for (int i = 0; i < 7; i++) step();
    @(negedge clk) chip_rst = 1;
    for (int i = 0; i < 3; i++) step();
    check_val("R11 drive_en low", drive_en, 0);
    expect_pos(0, "R11 reload under steps");
    chip_rst = 0; settle(8);
    expect_pos(0, "R11 no pending step");
    step(); expect_pos(1, "R11 steps after release");
  endtask

  initial begin
    t_reset();
    t_micro();
    t_full();
    t_half();
    t_realign();
    t_oe();
    t_psave();
    t_chiprst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule